// File: doc/BRIEF.md
# Two-Bank SDRAM Command Timing Monitor

This block sits beside the command pins of a two-bank synchronous DRAM and watches every rising clock edge. It decodes the chip-select, row-strobe, column-strobe and write-enable pins into a command, takes the bank from A11 and the auto-precharge or all-banks qualifier from A10, and keeps a state machine and a set of elapsed-cycle counters for each bank. Whenever a command breaks a minimum spacing or arrives in a state where it is not allowed, the block raises a flag for that kind of violation. The flag stays set until software-independent logic pulses the clear input.

The minimum spacings are parameters in clock cycles: activate to column command, precharge to activate, activate to activate on one bank, activate to activate across banks, write recovery, and mode set to activate. The burst length is also a parameter. The block never drives the memory and never checks data. It is meant for simulation monitors or for on-chip command-stream policing in a memory controller.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: `cmd_code` shows, one edge later, the command decoded from the pins, regardless of CKE. The pins are taken as {cs_n,ras_n,cas_n,we_n}. The codes are: cs_n high gives 0 (deselect); 0111 and 0110 give 1 (no-op); 0011 gives 2 (activate); 0101 gives 3 (read); 0100 gives 4 (write); 0010 gives 5 (precharge); 0001 gives 6 (auto-refresh); 0000 gives 7 (mode set).
- R2: `bank_state` holds bank 0 in bits [2:0] and bank 1 in bits [5:3]. The codes are 0 idle, 1 row open, 2 reading, 3 writing and 4 precharging. After reset both banks are idle, and `cmd_code` and `viol` are zero. An accepted activate on the bank selected by A11 shows as 1 after that edge.
- R3: A read or write to a bank fewer than TRCD edges after its activate sets `viol[0]`.
- R4: An activate to a bank that is still precharging (fewer than TRP edges since the precharge started) sets `viol[1]` and is not accepted. An accepted activate fewer than TRC edges after the previous activate or refresh of that bank sets `viol[2]`.
- R5: An activate to the other bank fewer than TRRD edges after the last accepted activate sets `viol[3]`.
- R6: A precharge to a bank fewer than TWR edges after its last write data beat sets `viol[4]`. Write data is taken on the command edge and on the following BURST-1 edges. A beat that falls on the precharge edge is dropped.
- R7: Each of these sets `viol[5]` and has no effect on state: an activate to a bank with a row open; a read or write to a bank that is idle or precharging; any read, write or precharge to a bank that has auto-precharge pending.
- R8: A read or write with A10 high enters precharge once the burst has ended. After a read this is on the edge BURST edges after the command. After a write it waits until TWR edges have passed since the last beat.
- R9: A precharge with A10 high closes every open bank. With A10 low it closes only the bank given by A11. Banks that are already idle are not affected.
- R10: An auto-refresh or mode set issued while any bank is not idle sets `viol[6]` and is not accepted. An accepted refresh restarts the TRC window of both banks.
- R11: An activate fewer than TMRD edges after an accepted mode set sets `viol[7]`.
- R12: CKE falling while any bank is not idle sets `viol[8]`. A command on an edge that follows an edge with CKE low is ignored.
- R13: Violation flags are sticky. A high `clr_flags` at an edge clears them, but a violation detected on that same edge still sets its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory command clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_flags | input | 1 | Clears all violation flags |
| cke | input | 1 | Clock enable pin of the memory |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| a10 | input | 1 | Auto-precharge / all-banks qualifier |
| a11 | input | 1 | Bank select |
| bank_state | output | 6 | State code of bank 1 (upper) and bank 0 (lower) |
| cmd_code | output | 3 | Command decoded at the previous edge |
| viol | output | 9 | Sticky violation flags |

## Verification
The bench sweeps each spacing across the edge where a command turns from illegal to legal. A design with an off-by-one counter would flag the first legal gap or miss the last illegal one. The write-recovery sweep covers the rule that a beat dropped by the precharge does not count as written; a design that counted it would flag every truncated burst. Auto-precharge is checked at the exact edge where the bank starts precharging, for reads and for writes. A write that skipped recovery would show precharging one edge early. Precharge-all against single-bank precharge, refresh restarting the cycle window, and commands ignored after CKE drops are also exercised, since each of these moves state that a careless design would leave untouched.

// File: rtl/sdmon_pkg.sv
`timescale 1ns/1ps
package sdmon_pkg;

    typedef enum logic [2:0] {
        C_DESEL = 3'd0,
        C_NOP   = 3'd1,
        C_ACT   = 3'd2,
        C_RD    = 3'd3,
        C_WR    = 3'd4,
        C_PRE   = 3'd5,
        C_REF   = 3'd6,
        C_MRS   = 3'd7
    } cmd_e;

    typedef enum logic [2:0] {
        B_IDLE = 3'd0,
        B_OPEN = 3'd1,
        B_RD   = 3'd2,
        B_WR   = 3'd3,
        B_PRE  = 3'd4
    } bst_e;

    typedef struct packed {
        cmd_e op;
        logic ap;   // A10 qualifier
        logic bk;   // A11 bank select
    } req_t;

    localparam int NBANK   = 2;
    localparam int NV      = 9;
    localparam int V_RCD   = 0;
    localparam int V_RP    = 1;
    localparam int V_RC    = 2;
    localparam int V_RRD   = 3;
    localparam int V_WR    = 4;
    localparam int V_STATE = 5;
    localparam int V_BUSY  = 6;
    localparam int V_MRD   = 7;
    localparam int V_CKE   = 8;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic cmd_e decode_pins(input logic cs_n, input logic ras_n,
                                         input logic cas_n, input logic we_n);
        cmd_e r;
        if (cs_n) begin
            r = C_DESEL;
        end else begin
            case ({ras_n, cas_n, we_n})
                3'b011:  r = C_ACT;
                3'b101:  r = C_RD;
                3'b100:  r = C_WR;
                3'b010:  r = C_PRE;
                3'b001:  r = C_REF;
                3'b000:  r = C_MRS;
                default: r = C_NOP;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/sdmon_decode.sv
`timescale 1ns/1ps
module sdmon_decode
    import sdmon_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic a10,
    input  logic a11,
    output req_t req_o
);
    always_comb begin
        req_o.op = decode_pins(cs_n, ras_n, cas_n, we_n);
        req_o.ap = a10;
        req_o.bk = a11;
    end
endmodule

// File: rtl/sdmon_bank.sv
`timescale 1ns/1ps
module sdmon_bank
    import sdmon_pkg::*;
#(
    parameter int ID    = 0,
    parameter int TRCD  = 2,
    parameter int TRP   = 2,
    parameter int TRC   = 7,
    parameter int TWR   = 1,
    parameter int BURST = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  req_t          req,
    input  logic          ref_go,
    output bst_e          st_o,
    output logic          idle_o,
    output logic          act_go_o,
    output logic [NV-1:0] hit_o
);
    localparam int TMAX = imax(imax(TRCD, TRP), imax(TRC, TWR));
    localparam int CW   = $clog2(TMAX + 1) + 1;
    localparam int BW   = $clog2(BURST + 1);
    typedef logic [CW-1:0] cnt_t;
    localparam cnt_t CMAX  = '1;
    localparam cnt_t K_RCD = cnt_t'(TRCD);
    localparam cnt_t K_RP  = cnt_t'(TRP);
    localparam cnt_t K_RC  = cnt_t'(TRC);
    localparam cnt_t K_WR  = cnt_t'(TWR);
    localparam logic MYBK  = ID[0];

    bst_e          st;
    cnt_t          rcd_c, rc_c, rp_c, wr_c;
    logic [BW-1:0] left;
    logic          apd;

    logic tgt, pre_tgt, is_open, idle_e, do_act, do_col, do_pre;

    assign tgt     = (req.bk == MYBK);
    assign pre_tgt = req.ap | tgt;
    assign is_open = (st == B_OPEN) || (st == B_RD) || (st == B_WR);
    assign idle_e  = (st == B_IDLE) || ((st == B_PRE) && (rp_c >= K_RP));

    always_comb begin
        hit_o  = '0;
        do_act = 1'b0;
        do_col = 1'b0;
        do_pre = 1'b0;
        if (run) begin
            case (req.op)
                C_ACT: if (tgt) begin
                    if (idle_e) begin
                        do_act = 1'b1;
                        if (rc_c < K_RC) hit_o[V_RC] = 1'b1;
                    end else if (st == B_PRE) begin
                        hit_o[V_RP] = 1'b1;
                    end else begin
                        hit_o[V_STATE] = 1'b1;
                    end
                end
                C_RD, C_WR: if (tgt) begin
                    if (!is_open || apd) begin
                        hit_o[V_STATE] = 1'b1;
                    end else begin
                        do_col = 1'b1;
                        if (rcd_c < K_RCD) hit_o[V_RCD] = 1'b1;
                    end
                end
                C_PRE: if (pre_tgt) begin
                    if (apd) begin
                        hit_o[V_STATE] = 1'b1;
                    end else if (is_open) begin
                        do_pre = 1'b1;
                        if (wr_c < K_WR) hit_o[V_WR] = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= B_IDLE;
            rcd_c <= CMAX;
            rc_c  <= CMAX;
            rp_c  <= CMAX;
            wr_c  <= CMAX;
            left  <= '0;
            apd   <= 1'b0;
        end else begin
            rcd_c <= (rcd_c == CMAX) ? rcd_c : rcd_c + 1'b1;
            rc_c  <= (rc_c  == CMAX) ? rc_c  : rc_c  + 1'b1;
            rp_c  <= (rp_c  == CMAX) ? rp_c  : rp_c  + 1'b1;
            wr_c  <= (wr_c  == CMAX) ? wr_c  : wr_c  + 1'b1;
            if (ref_go) rc_c <= cnt_t'(1);
            if (do_act) begin
                st    <= B_OPEN;
                rcd_c <= cnt_t'(1);
                rc_c  <= cnt_t'(1);
                apd   <= 1'b0;
            end else if (do_col) begin
                st   <= (req.op == C_WR) ? B_WR : B_RD;
                left <= BW'(BURST - 1);
                apd  <= req.ap;
                if (req.op == C_WR) wr_c <= cnt_t'(1);
            end else if (do_pre) begin
                st   <= B_PRE;
                rp_c <= cnt_t'(1);
            end else if (run && ((st == B_RD) || (st == B_WR))) begin
                if (left != '0) begin
                    left <= left - 1'b1;
                    if (st == B_WR) wr_c <= cnt_t'(1);
                end else if (!apd) begin
                    st <= B_OPEN;
                end else if (wr_c >= K_WR) begin
                    st   <= B_PRE;
                    rp_c <= cnt_t'(1);
                    apd  <= 1'b0;
                end
            end else if ((st == B_PRE) && (rp_c >= K_RP)) begin
                st <= B_IDLE;
            end
        end
    end

    assign st_o     = st;
    assign idle_o   = idle_e;
    assign act_go_o = do_act;
endmodule

// File: rtl/sdram_cmd_monitor.sv
`timescale 1ns/1ps
module sdram_cmd_monitor
    import sdmon_pkg::*;
#(
    parameter int TRCD  = 2,
    parameter int TRP   = 2,
    parameter int TRC   = 7,
    parameter int TRRD  = 2,
    parameter int TWR   = 1,
    parameter int TMRD  = 2,
    parameter int BURST = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr_flags,
    input  logic       cke,
    input  logic       cs_n,
    input  logic       ras_n,
    input  logic       cas_n,
    input  logic       we_n,
    input  logic       a10,
    input  logic       a11,
    output logic [5:0] bank_state,
    output logic [2:0] cmd_code,
    output logic [8:0] viol
);
    localparam int GW = $clog2(imax(TRRD, TMRD) + 1) + 1;
    typedef logic [GW-1:0] gcnt_t;
    localparam gcnt_t GMAX  = '1;
    localparam gcnt_t K_RRD = gcnt_t'(TRRD);
    localparam gcnt_t K_MRD = gcnt_t'(TMRD);

    req_t             req;
    logic             cke_q, run, all_idle, ref_go;
    bst_e             st_w  [NBANK];
    logic [NV-1:0]    bhit  [NBANK];
    logic [NBANK-1:0] idle_w, act_w;
    logic [NV-1:0]    ghit;
    gcnt_t            rrd_c, mrd_c;
    logic             last_bk;

    sdmon_decode u_dec (
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .a10(a10), .a11(a11), .req_o(req)
    );

    assign run      = cke_q;
    assign all_idle = &idle_w;
    assign ref_go   = run && (req.op == C_REF) && all_idle;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        sdmon_bank #(
            .ID(b), .TRCD(TRCD), .TRP(TRP), .TRC(TRC), .TWR(TWR), .BURST(BURST)
        ) u_bank (
            .clk(clk), .rst(rst), .run(run), .req(req), .ref_go(ref_go),
            .st_o(st_w[b]), .idle_o(idle_w[b]), .act_go_o(act_w[b]),
            .hit_o(bhit[b])
        );
    end

    always_comb begin
        ghit = '0;
        if (run && (req.op == C_ACT)) begin
            if ((req.bk != last_bk) && (rrd_c < K_RRD)) ghit[V_RRD] = 1'b1;
            if (mrd_c < K_MRD) ghit[V_MRD] = 1'b1;
        end
        if (run && ((req.op == C_REF) || (req.op == C_MRS)) && !all_idle)
            ghit[V_BUSY] = 1'b1;
        if (cke_q && !cke && !all_idle)
            ghit[V_CKE] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cke_q    <= 1'b1;
            rrd_c    <= GMAX;
            mrd_c    <= GMAX;
            last_bk  <= 1'b0;
            viol     <= '0;
            cmd_code <= 3'd0;
        end else begin
            cke_q    <= cke;
            cmd_code <= req.op;
            rrd_c    <= (rrd_c == GMAX) ? rrd_c : rrd_c + 1'b1;
            mrd_c    <= (mrd_c == GMAX) ? mrd_c : mrd_c + 1'b1;
            if (|act_w) begin
                rrd_c   <= gcnt_t'(1);
                last_bk <= act_w[1];
            end
            if (run && (req.op == C_MRS) && all_idle) mrd_c <= gcnt_t'(1);
            viol <= (clr_flags ? '0 : viol) | ghit | bhit[0] | bhit[1];
        end
    end

    assign bank_state = {st_w[1], st_w[0]};
endmodule

// File: rtl/sdmon_chk.sv
`timescale 1ns/1ps
module sdmon_chk (
    input logic       clk,
    input logic       rst,
    input logic       clr_flags,
    input logic       cke,
    input logic       cs_n,
    input logic       ras_n,
    input logic       cas_n,
    input logic       we_n,
    input logic       a11,
    input logic [5:0] bank_state,
    input logic [2:0] cmd_code,
    input logic [8:0] viol
);
    a_r1_deselect_code: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> (cmd_code == 3'd0));

    a_r2_open_needs_act: assert property (@(posedge clk) disable iff (rst)
        ((bank_state[2:0] == 3'd1) && ($past(bank_state[2:0]) == 3'd0))
        |-> $past(!cs_n && !ras_n && cas_n && we_n && !a11));

    a_r7_read_from_open: assert property (@(posedge clk) disable iff (rst)
        ((bank_state[2:0] == 3'd2) && ($past(bank_state[2:0]) != 3'd2))
        |-> (($past(bank_state[2:0]) == 3'd1) || ($past(bank_state[2:0]) == 3'd3)));

    a_r12_cke_drop_flag: assert property (@(posedge clk) disable iff (rst)
        ($past(cke) && !cke && (bank_state[2:0] == 3'd1)) |=> viol[8]);

    a_r13_flags_sticky: assert property (@(posedge clk) disable iff (rst)
        !clr_flags |=> ((viol & $past(viol)) == $past(viol)));
endmodule

bind sdram_cmd_monitor sdmon_chk u_chk (
    .clk(clk), .rst(rst), .clr_flags(clr_flags), .cke(cke),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .a11(a11),
    .bank_state(bank_state), .cmd_code(cmd_code), .viol(viol)
);

// File: tb/sdram_cmd_monitor_tb.sv
`timescale 1ns/1ps
module sdram_cmd_monitor_tb_top;
    localparam logic [3:0] P_DES = 4'b1111;
    localparam logic [3:0] P_NOP = 4'b0111;
    localparam logic [3:0] P_ACT = 4'b0011;
    localparam logic [3:0] P_RD  = 4'b0101;
    localparam logic [3:0] P_WR  = 4'b0100;
    localparam logic [3:0] P_PRE = 4'b0010;
    localparam logic [3:0] P_REF = 4'b0001;
    localparam logic [3:0] P_MRS = 4'b0000;

    logic clk = 1'b0;
    logic rst, clr_flags, cke, cs_n, ras_n, cas_n, we_n, a10, a11;
    logic [5:0] bank_state;
    logic [2:0] cmd_code;
    logic [8:0] viol;
    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sdram_cmd_monitor #(.TWR(2)) dut_i (
        .clk(clk), .rst(rst), .clr_flags(clr_flags), .cke(cke),
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .a10(a10), .a11(a11), .bank_state(bank_state),
        .cmd_code(cmd_code), .viol(viol)
    );

    task automatic chk(input string tag, input int got, input int exp);
        tests++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
        end
    endtask

    task automatic cmd(input logic [3:0] p, input logic x10, input logic x11);
        {cs_n, ras_n, cas_n, we_n} = p;
        a10 = x10;
        a11 = x11;
        @(posedge clk);
        #1;
        {cs_n, ras_n, cas_n, we_n} = P_NOP;
        a10 = 1'b0;
        a11 = 1'b0;
    endtask

    task automatic nop(input int n);
        for (int i = 0; i < n; i++) cmd(P_NOP, 1'b0, 1'b0);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        clr_flags = 1'b0;
        cke = 1'b1;
        {cs_n, ras_n, cas_n, we_n} = P_NOP;
        a10 = 1'b0;
        a11 = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        rst = 1'b0;
    endtask

    function automatic int exp_code(input logic [3:0] p);
        if (p[3]) return 0;
        case (p[2:0])
            3'b011: return 2;
            3'b101: return 3;
            3'b100: return 4;
            3'b010: return 5;
            3'b001: return 6;
            3'b000: return 7;
            default: return 1;
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog got=0 exp=1");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        // R2 / R13: reset state
        do_reset();
        chk("R2 reset state", bank_state, 0);
        chk("R13 reset flags", viol, 0);
        chk("R1 reset code", cmd_code, 0);

        // R1: all pin patterns
        for (int v = 0; v < 16; v++) begin
            do_reset();
            cmd(v[3:0], 1'b0, 1'b0);
            chk("R1 decode", cmd_code, exp_code(v[3:0]));
        end

        // R3: activate-to-read spacing
        for (int g = 1; g <= 4; g++) begin
            do_reset();
            cmd(P_ACT, 1'b0, 1'b0);
            chk("R2 open after act", bank_state[2:0], 1);
            nop(g - 1);
            cmd(P_RD, 1'b0, 1'b0);
            chk("R3 rcd", viol[0], (g < 2) ? 1 : 0);
            chk("R2 reading", bank_state[2:0], 2);
        end

        // R4: precharge then activate
        for (int g = 2; g <= 9; g++) begin
            do_reset();
            cmd(P_ACT, 1'b0, 1'b0);
            cmd(P_PRE, 1'b0, 1'b0);
            if (g == 2) chk("R9 single close", bank_state[2:0], 4);
            nop(g - 2);
            cmd(P_ACT, 1'b0, 1'b0);
            chk("R4 rp", viol[1], (g - 1 < 2) ? 1 : 0);
            chk("R4 rc", viol[2], ((g - 1 >= 2) && (g < 7)) ? 1 : 0);
        end

        // R5: cross-bank activate spacing
        for (int g = 1; g <= 3; g++) begin
            do_reset();
            cmd(P_ACT, 1'b0, 1'b0);
            nop(g - 1);
            cmd(P_ACT, 1'b0, 1'b1);
            chk("R5 rrd", viol[3], (g < 2) ? 1 : 0);
        end

        // R6: write recovery with TWR=2, write at edge 2, beats 2..5
        for (int p = 3; p <= 8; p++) begin
            do_reset();
            cmd(P_ACT, 1'b0, 1'b0);
            nop(1);
            cmd(P_WR, 1'b0, 1'b0);
            nop(p - 3);
            cmd(P_PRE, 1'b0, 1'b0);
            chk("R6 wr", viol[4], (p <= 6) ? 1 : 0);
        end

        // R7: illegal state commands
        do_reset();
        cmd(P_RD, 1'b0, 1'b1);
        chk("R7 read idle", viol[5], 1);
        chk("R7 read idle no effect", bank_state, 0);
        do_reset();
        cmd(P_ACT, 1'b0, 1'b0);
        nop(1);
        cmd(P_ACT, 1'b0, 1'b0);
        chk("R7 act open", viol[5], 1);
        chk("R7 act open no rc", viol[2], 0);

        // R8: read with auto precharge
        for (int g = 7; g <= 8; g++) begin
            do_reset();
            cmd(P_ACT, 1'b0, 1'b0);
            nop(1);
            cmd(P_RD, 1'b1, 1'b0);
            nop(3);
            chk("R8 rd burst", bank_state[2:0], 2);
            nop(1);
            chk("R8 rd ap start", bank_state[2:0], 4);
            nop(g - 7);
            cmd(P_ACT, 1'b0, 1'b0);
            chk("R8 act after ap", viol[1], (g == 7) ? 1 : 0);
            if (g == 8) chk("R8 reopen", bank_state[2:0], 1);
        end
        // R8: write with auto precharge waits for recovery
        do_reset();
        cmd(P_ACT, 1'b0, 1'b0);
        nop(1);
        cmd(P_WR, 1'b1, 1'b0);
        nop(4);
        chk("R8 wr recovery", bank_state[2:0], 3);
        nop(1);
        chk("R8 wr ap start", bank_state[2:0], 4);
        // R7: read during pending auto precharge
        do_reset();
        cmd(P_ACT, 1'b0, 1'b0);
        nop(1);
        cmd(P_RD, 1'b1, 1'b0);
        nop(1);
        cmd(P_RD, 1'b0, 1'b0);
        chk("R7 col during ap", viol[5], 1);

        // R9: precharge all versus single
        do_reset();
        cmd(P_ACT, 1'b0, 1'b0);
        nop(1);
        cmd(P_ACT, 1'b0, 1'b1);
        nop(1);
        cmd(P_PRE, 1'b1, 1'b0);
        chk("R9 all", bank_state, {3'd4, 3'd4});
        do_reset();
        cmd(P_ACT, 1'b0, 1'b0);
        nop(1);
        cmd(P_ACT, 1'b0, 1'b1);
        nop(1);
        cmd(P_PRE, 1'b0, 1'b1);
        chk("R9 one", bank_state, {3'd4, 3'd1});

        // R10: refresh / mode set need all banks idle
        do_reset();
        cmd(P_ACT, 1'b0, 1'b0);
        cmd(P_REF, 1'b0, 1'b0);
        chk("R10 ref busy", viol[6], 1);
        chk("R10 ref busy state", bank_state[2:0], 1);
        do_reset();
        cmd(P_ACT, 1'b0, 1'b1);
        cmd(P_MRS, 1'b0, 1'b0);
        chk("R10 mrs busy", viol[6], 1);
        do_reset();
        cmd(P_REF, 1'b0, 1'b0);
        chk("R10 ref idle", viol, 0);
        for (int g = 1; g <= 8; g++) begin
            do_reset();
            cmd(P_REF, 1'b0, 1'b0);
            nop(g - 1);
            cmd(P_ACT, 1'b0, 1'b1);
            chk("R10 ref rc", viol[2], (g < 7) ? 1 : 0);
        end

        // R11: mode set to activate
        for (int g = 1; g <= 3; g++) begin
            do_reset();
            cmd(P_MRS, 1'b0, 1'b0);
            nop(g - 1);
            cmd(P_ACT, 1'b0, 1'b0);
            chk("R11 mrd", viol[7], (g < 2) ? 1 : 0);
        end

        // R12: clock enable
        do_reset();
        cmd(P_ACT, 1'b0, 1'b0);
        cke = 1'b0;
        nop(1);
        chk("R12 cke drop busy", viol[8], 1);
        cmd(P_ACT, 1'b0, 1'b1);
        chk("R12 ignored act", bank_state[5:3], 0);
        do_reset();
        cke = 1'b0;
        nop(1);
        chk("R12 cke drop idle", viol[8], 0);
        cke = 1'b1;

        // R13: sticky and clear
        do_reset();
        cmd(P_WR, 1'b0, 1'b0);
        nop(2);
        chk("R13 sticky", viol[5], 1);
        clr_flags = 1'b1;
        nop(1);
        clr_flags = 1'b0;
        chk("R13 cleared", viol, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule